// File: doc/BRIEF.md
# Iterative 16x16 Multiplier with Condition Flags

This block multiplies two 16-bit operands, taken as unsigned or as two's complement according to a mode input. The full 32-bit product is meant to replace the entire destination register. One operand is the low half of that register and the other is a word-sized source. The caller raises `start_i` for one cycle while the block is idle. The block captures both operands and the mode at that edge. It then runs a shift-and-add loop that handles one multiplier bit per step, and pads the run to a fixed latency set by a parameter (70 cycles by default).

When the run ends, `done_o` pulses for one cycle. At the same edge the product and the four condition flags update. N copies product bit 31 and Z marks a zero product. V and C are always cleared. The product and the flags then hold until the next run ends. A start request that arrives while the block is busy is dropped.

Top module: `mul16_iter`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `product_o` and all four flag outputs are 0.
- R2: A `start_i` high at a rising edge while `busy_o` is low is accepted. `busy_o` is then high for exactly LATENCY cycles.
- R3: `done_o` is high for exactly one cycle. It rises at the LATENCY-th edge after the accepting edge, and `busy_o` falls at that same edge.
- R4: With `signed_i`=0 at acceptance, `product_o` is the unsigned 32-bit product of `op_a_i` and `op_b_i`.
- R5: With `signed_i`=1 at acceptance, `product_o` is the 32-bit two's-complement product of the two operands. This includes -32768 times -32768, which gives 0x40000000.
- R6: Operands and mode are captured at the accepting edge. Changing them during a run does not alter its result.
- R7: `start_i` raised while `busy_o` is high is ignored. The running operation keeps its timing and its result.
- R8: A `start_i` in the cycle where `done_o` is high is accepted, so runs can follow back to back.
- R9: At completion `flag_n_o` equals `product_o[31]`, and `flag_z_o` is 1 exactly when `product_o` is zero.
- R10: At completion `flag_v_o` and `flag_c_o` are 0.
- R11: Between completions `product_o` and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply (accepted only when idle) |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a_i | input | 16 | Low half of the destination register |
| op_b_i | input | 16 | Word-sized source operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 32 | Full product, the new destination value |
| flag_n_o | output | 1 | Negative: product bit 31 |
| flag_z_o | output | 1 | Zero: product equals zero |
| flag_v_o | output | 1 | Overflow, cleared on completion |
| flag_c_o | output | 1 | Carry, cleared on completion |

## Verification
Two events can fall in the same cycle: the completion of one run and the acceptance of the next. The bench provokes this by raising `start_i` with new operands in the very cycle `done_o` is high. It then checks that the first product has already landed, and that the second run keeps full latency and produces its own result. A second collision is a start request issued mid-run with different operands. For that case the bench checks that neither the completion edge nor the product moves.

// File: rtl/mul16_pkg.sv
package mul16_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } mul_flags_t;
endpackage

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int unsigned STEPS   = 16,
  parameter int unsigned LATENCY = 70
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST  = CW'(LATENCY - 1);
  localparam logic [CW-1:0] NSTEP = CW'(STEPS);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign load_o   = start_i && !busy_q;
  assign step_o   = busy_q && (cnt_q < NSTEP);
  assign finish_o = busy_q && (cnt_q == LAST);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= finish_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (finish_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R3
  AST_RUN_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> (done_q && !busy_q)); // R3
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             finish_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic [2*WIDTH-1:0] result_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0]    mcand_q, acc_q;
  logic [WIDTH-1:0] mplier_q;
  logic             neg_q;
  logic [WIDTH-1:0] mag_a, mag_b;

  // magnitudes; -2^(W-1) maps to 2^(W-1), which still fits unsigned
  assign mag_a = (signed_i && op_a_i[WIDTH-1]) ? (~op_a_i + 1'b1) : op_a_i;
  assign mag_b = (signed_i && op_b_i[WIDTH-1]) ? (~op_b_i + 1'b1) : op_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      neg_q    <= 1'b0;
    end else if (load_i) begin
      mcand_q  <= {{WIDTH{1'b0}}, mag_a};
      mplier_q <= mag_b;
      acc_q    <= '0;
      neg_q    <= signed_i && (op_a_i[WIDTH-1] ^ op_b_i[WIDTH-1]);
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign result_o = neg_q ? (~acc_q + 1'b1) : acc_q;

  AST_MPLIER_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |-> (mplier_q == '0)); // R4
  AST_STEP_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(acc_q) && $stable(mplier_q))); // R6
endmodule

// File: rtl/mul16_iter.sv
module mul16_iter
  import mul16_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned LATENCY = 70
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   op_a_i,
  input  logic [WIDTH-1:0]   op_b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o,
  output logic               flag_n_o,
  output logic               flag_z_o,
  output logic               flag_v_o,
  output logic               flag_c_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic          load, step, finish;
  logic [PW-1:0] result, product_q;
  mul_flags_t    flags_q;

  mul_seq_ctrl #(.STEPS(WIDTH), .LATENCY(LATENCY)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  mul_shift_add #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .finish_i (finish),
    .signed_i (signed_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .result_o (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      product_q <= '0;
      flags_q   <= '0;
    end else if (finish) begin
      product_q <= result;
      flags_q.n <= result[PW-1];
      flags_q.z <= (result == '0);
      flags_q.v <= 1'b0;
      flags_q.c <= 1'b0;
    end
  end

  assign product_o = product_q;
  assign flag_n_o  = flags_q.n;
  assign flag_z_o  = flags_q.z;
  assign flag_v_o  = flags_q.v;
  assign flag_c_o  = flags_q.c;

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(product_o) && $stable(flags_q))); // R11
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flag_n_o == product_o[PW-1])); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flag_z_o == (product_o == '0))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R3
endmodule

// File: tb/mul16_iter_tb_top.sv
module mul16_iter_tb_top;
  localparam int unsigned LAT    = 70;
  localparam time         CLK_PS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        busy, done, fn, fz, fv, fc;
  logic [31:0] prod;

  int checks = 0, errors = 0;

  always #(CLK_PS/2) clk = ~clk;

  mul16_iter #(.WIDTH(16), .LATENCY(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .op_a_i(a), .op_b_i(b), .busy_o(busy), .done_o(done),
    .product_o(prod), .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  function automatic logic [31:0] exp_prod(logic [15:0] x, logic [15:0] y, logic s);
    logic signed [31:0] sx, sy;
    if (s) begin
      sx = $signed({{16{x[15]}}, x});
      sy = $signed({{16{y[15]}}, y});
      return 32'(sx * sy);
    end
    return {16'b0, x} * {16'b0, y};
  endfunction

  task automatic check(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Call at a negedge; ends at the negedge after the completion edge.
  // mode 1: operands altered mid-run; mode 2: start re-raised mid-run.
  task automatic run_op(logic [15:0] x, logic [15:0] y, logic s, int mode, string req);
    logic [31:0] e;
    logic        bad = 1'b0;
    e = exp_prod(x, y, s);
    a = x; b = y; sgn = s; start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (mode == 1 && i == 3) begin a = ~x; b = y + 16'd7; sgn = ~s; end
      if (mode == 2 && i == 5) begin a = 16'h1234; b = 16'h5678; start = 1'b1; end
      if (!busy || done) bad = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    check(!bad, "R2 busy held for LATENCY", 32'(busy), 32'd1);
    check(done && !busy, "R3 done at LATENCY edge", {30'b0, done, busy}, 32'd2);
    check(prod == e, req, prod, e);
    check(fn == e[31] && fz == (e == 0), "R9 N/Z flags", {30'b0, fn, fz}, {30'b0, e[31], e == 0});
    check(!fv && !fc, "R10 V/C cleared", {30'b0, fv, fc}, 32'd0);
  endtask

  initial begin
    int unsigned seed_dummy;
    logic [31:0] held;
    seed_dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    check(!busy && !done && prod == 0 && !fn && !fz && !fv && !fc,
          "R1 reset state", prod, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(16'd3, 16'd5, 1'b0, 0, "R4 unsigned small");
    @(negedge clk);
    check(!done, "R3 done single cycle", 32'(done), 32'd0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0, 0, "R4 unsigned max");
    run_op(16'hFFFF, 16'hFFFF, 1'b1, 0, "R5 signed -1*-1");
    run_op(16'h8000, 16'h8000, 1'b1, 0, "R5 signed min*min");
    run_op(16'h8000, 16'h7FFF, 1'b1, 0, "R5 signed min*max");
    run_op(16'h0000, 16'hBEEF, 1'b1, 0, "R5 zero product");
    run_op(16'hFFF0, 16'h0010, 1'b1, 1, "R6 operands altered mid-run");
    run_op(16'h0102, 16'h0304, 1'b0, 2, "R7 start while busy ignored");
    // R8: start issued in the done cycle
    run_op(16'h00FF, 16'h0101, 1'b0, 0, "R8 back-to-back first");
    run_op(16'hFF00, 16'h0003, 1'b1, 0, "R8 back-to-back second");

    @(negedge clk);
    held = prod;
    a = 16'hAAAA; b = 16'h5555; sgn = 1'b1;
    repeat (10) @(negedge clk);
    check(prod == held && !done && !busy, "R11 result held when idle", prod, held);

    for (int k = 0; k < 24; k++) begin
      logic [15:0] rx, ry;
      logic        rs;
      rx = 16'($urandom); ry = 16'($urandom); rs = 1'($urandom);
      run_op(rx, ry, rs, 0, rs ? "R5 random signed" : "R4 random unsigned");
      if (k % 3 == 0) @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule